// File: doc/BRIEF.md
# Carry-Select Adder/Subtractor Slice

This block adds or subtracts two W-bit operands in one combinational pass. Every bit position computes its result in advance for both possible incoming carries. Two carry chains run the full width side by side. One chain starts from an assumed carry of 0 and the other from an assumed carry of 1.

The real block carry-in arrives late and only chooses between the two chains. At each bit, the carry on the chosen chain decides which of the two precomputed sum bits appears at the output. A run-time control makes the block subtract instead of add: when it is set, every bit of B is inverted.

The result is offered in two forms. The combinational form is available in the same cycle. The registered form has a clock enable and a synchronous clear. Slices can be cascaded by feeding one slice's carry-out into the next slice's carry-in.

Top module: `csel_addsub_slice`

## Requirements
- R1: With `sub`=0, `{cout, sum_comb}` equals `a + b + cin`, taken as an unsigned (W+1)-bit value.
- R2: With `sub`=1 and `cin`=1, `sum_comb` equals `a - b` modulo 2^W. `cout` is 1 exactly when `a >= b` (unsigned), meaning no borrow occurred.
- R3: With `sub`=1 and `cin`=0, `{cout, sum_comb}` equals `a + ~b`, which is `a - b - 1` modulo 2^W.
- R4: `cin` only chooses between precomputed results. For fixed `a`, `b` and `sub`, the value `{cout,sum_comb}` with `cin`=1 is exactly one more than the value with `cin`=0. Internally, wherever the carry-0 chain carries, the carry-1 chain carries too.
- R5: `sum_comb` and `cout` follow `a`, `b`, `cin` and `sub` without any clock edge. Changing `sub` between cycles switches the operation immediately.
- R6: On a rising edge of `clk` with `clr`=0 and `en`=1, `sum_reg` takes the value `sum_comb` had before that edge.
- R7: On a rising edge with `clr`=0 and `en`=0, `sum_reg` keeps its value.
- R8: On a rising edge with `clr`=1, `sum_reg` becomes 0, whatever the value of `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| clr | input | 1 | Synchronous active-high clear of `sum_reg` |
| en | input | 1 | Load enable for `sum_reg` |
| sub | input | 1 | 0 = add, 1 = subtract (B inverted) |
| cin | input | 1 | Block carry-in, selects the carry chain |
| a | input | W | Operand A |
| b | input | W | Operand B |
| sum_comb | output | W | Combinational sum |
| sum_reg | output | W | Registered sum |
| cout | output | 1 | Carry-out of the selected chain |

## Verification
The embedded assertions check the following on every cycle:
- the add and subtract results against plain arithmetic;
- that the carry-1 chain carries wherever the carry-0 chain does;
- that the register loads, holds and clears as required.

Some behaviour can only be shown by the bench's directed scenarios:
- the off-by-one relation between the two `cin` settings;
- the boundary operands (all ones plus one, zero minus one, equal operands);
- immediate switching of `sub` without a clock edge;
- clear taking priority over enable.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Per-bit results prepared for both possible local carries
    typedef struct packed {
        logic s_lo;   // sum bit if the incoming carry is 0
        logic s_hi;   // sum bit if the incoming carry is 1
        logic k_lo;   // carry out if the incoming carry is 0
        logic k_hi;   // carry out if the incoming carry is 1
    } cell_out_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Operand B as seen by the cell: inverted when subtracting
    function automatic logic cond_invert(input logic bit_in, input op_e op);
        return (op == OP_SUB) ? ~bit_in : bit_in;
    endfunction

endpackage

// File: rtl/csel_cell.sv
module csel_cell
    import csel_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  op_e       op,
    output cell_out_t res
);
    logic b_eff;

    always_comb begin
        b_eff     = cond_invert(b_i, op);
        // Four two-input functions of a_i and b_eff
        res.s_lo  = a_i ^ b_eff;
        res.s_hi  = ~(a_i ^ b_eff);
        res.k_lo  = a_i & b_eff;
        res.k_hi  = a_i | b_eff;
    end
endmodule

// File: rtl/csel_chain.sv
module csel_chain
    import csel_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W:0]   ch0,
    output logic [W:0]   ch1,
    output logic [W-1:0] s_lo,
    output logic [W-1:0] s_hi
);
    cell_out_t cells [W];

    assign ch0[0] = 1'b0;
    assign ch1[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csel_cell u_cell (
            .a_i (a[i]),
            .b_i (b[i]),
            .op  (op),
            .res (cells[i])
        );
        assign s_lo[i]  = cells[i].s_lo;
        assign s_hi[i]  = cells[i].s_hi;
        assign ch0[i+1] = ch0[i] ? cells[i].k_hi : cells[i].k_lo;
        assign ch1[i+1] = ch1[i] ? cells[i].k_hi : cells[i].k_lo;
    end
endmodule

// File: rtl/csel_select.sv
module csel_select #(
    parameter int W = 8
) (
    input  logic [W:0]   ch0,
    input  logic [W:0]   ch1,
    input  logic [W-1:0] s_lo,
    input  logic [W-1:0] s_hi,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] csel;

    for (genvar i = 0; i <= W; i++) begin : g_sel
        assign csel[i] = cin ? ch1[i] : ch0[i];
    end

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum[i] = csel[i] ? s_hi[i] : s_lo[i];
    end

    assign cout = csel[W];
endmodule

// File: rtl/csel_out_reg.sv
module csel_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (clr)     q <= '0;
        else if (en) q <= d;
    end

    // R6: load on enable
    p_load_r6: assert property (@(posedge clk) disable iff (clr)
        en |=> q == $past(d))
        else $error("p_load_r6");

    // R7: hold when disabled
    p_hold_r7: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(q))
        else $error("p_hold_r7");

    // R8: clear wins, checked one cycle after it is seen
    logic clr_seen;
    always_ff @(posedge clk) begin
        clr_seen <= clr;
        if (clr_seen == 1'b1) begin
            p_clear_r8: assert (q == '0) else $error("p_clear_r8");
        end
    end
endmodule

// File: rtl/csel_addsub_slice.sv
module csel_addsub_slice
    import csel_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic         sub,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_comb,
    output logic [W-1:0] sum_reg,
    output logic         cout
);
    localparam int WX = W + 1;

    op_e          op;
    logic [W:0]   ch0;
    logic [W:0]   ch1;
    logic [W-1:0] s_lo;
    logic [W-1:0] s_hi;

    assign op = sub ? OP_SUB : OP_ADD;

    csel_chain #(.W(W)) u_chain (
        .a    (a),
        .b    (b),
        .op   (op),
        .ch0  (ch0),
        .ch1  (ch1),
        .s_lo (s_lo),
        .s_hi (s_hi)
    );

    csel_select #(.W(W)) u_sel (
        .ch0  (ch0),
        .ch1  (ch1),
        .s_lo (s_lo),
        .s_hi (s_hi),
        .cin  (cin),
        .sum  (sum_comb),
        .cout (cout)
    );

    csel_out_reg #(.W(W)) u_reg (
        .clk (clk),
        .clr (clr),
        .en  (en),
        .d   (sum_comb),
        .q   (sum_reg)
    );

    // R1: addition
    p_add_r1: assert property (@(posedge clk) disable iff (clr)
        !sub |-> {cout, sum_comb} == ({1'b0, a} + {1'b0, b} + WX'(cin)))
        else $error("p_add_r1");

    // R2: subtraction with carry-in set
    p_sub_r2: assert property (@(posedge clk) disable iff (clr)
        (sub && cin) |-> (sum_comb == W'(a - b)) && (cout == (a >= b)))
        else $error("p_sub_r2");

    // R3: subtraction with carry-in clear
    p_subnc_r3: assert property (@(posedge clk) disable iff (clr)
        (sub && !cin) |-> {cout, sum_comb} == ({1'b0, a} + {1'b0, ~b}))
        else $error("p_subnc_r3");

    // R4: carry-1 chain dominates carry-0 chain
    p_chain_order_r4: assert property (@(posedge clk) disable iff (clr)
        (ch0 & ~ch1) == '0)
        else $error("p_chain_order_r4");
endmodule

// File: tb/csel_addsub_slice_tb.sv
module csel_addsub_slice_tb_top;
    localparam int W = 8;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         clr, en, sub, cin;
    logic [W-1:0] a, b;
    logic [W-1:0] sum_comb, sum_reg;
    logic         cout;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    csel_addsub_slice #(.W(W)) dut_i (
        .clk (clk), .clr (clr), .en (en), .sub (sub), .cin (cin),
        .a (a), .b (b), .sum_comb (sum_comb), .sum_reg (sum_reg), .cout (cout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int av, input int bv, input bit s, input bit c);
        @(negedge clk);
        a = W'(av); b = W'(bv); sub = s; cin = c;
        #1;
    endtask

    task automatic t_reset();
        clr = 1'b1; en = 1'b1; sub = 1'b0; cin = 1'b0; a = '0; b = '0;
        repeat (2) @(posedge clk);
        #1 chk("R8 reset", int'(sum_reg), 0);
        @(negedge clk); clr = 1'b0; en = 1'b0;
    endtask

    task automatic t_add();
        int av, bv, c;
        drive(M-1, 1, 0, 0);
        chk("R1 wrap", int'({cout, sum_comb}), M);
        drive(M-1, M-1, 0, 1);
        chk("R1 max", int'({cout, sum_comb}), 2*M-1);
        for (int k = 0; k < 40; k++) begin
            av = int'($urandom % M); bv = int'($urandom % M); c = int'($urandom % 2);
            drive(av, bv, 0, c[0]);
            chk("R1 rand", int'({cout, sum_comb}), av + bv + c);
        end
    endtask

    task automatic t_sub();
        int av, bv;
        drive(0, 1, 1, 1);
        chk("R2 zero-minus-one", int'(sum_comb), M-1);
        chk("R2 borrow", int'(cout), 0);
        drive(77, 77, 1, 1);
        chk("R2 equal", int'(sum_comb), 0);
        chk("R2 equal cout", int'(cout), 1);
        for (int k = 0; k < 40; k++) begin
            av = int'($urandom % M); bv = int'($urandom % M);
            drive(av, bv, 1, 1);
            chk("R2 rand", int'(sum_comb), (av - bv + M) % M);
            chk("R2 rand cout", int'(cout), (av >= bv) ? 1 : 0);
        end
    endtask

    task automatic t_sub_nocin();
        int av, bv;
        for (int k = 0; k < 20; k++) begin
            av = int'($urandom % M); bv = int'($urandom % M);
            drive(av, bv, 1, 0);
            chk("R3 rand", int'({cout, sum_comb}), av + (M - 1 - bv));
        end
    endtask

    task automatic t_cin_select();
        int av, bv, lo;
        bit s;
        for (int k = 0; k < 30; k++) begin
            av = int'($urandom % M); bv = int'($urandom % M); s = 1'($urandom % 2);
            drive(av, bv, s, 0);
            lo = int'({cout, sum_comb});
            drive(av, bv, s, 1);
            chk("R4 cin step", int'({cout, sum_comb}), lo + 1);
        end
    endtask

    task automatic t_sub_switch();
        @(negedge clk);
        a = W'(200); b = W'(50); cin = 1'b1; sub = 1'b0;
        #1 chk("R5 add now", int'(sum_comb), (251) % M);
        sub = 1'b1;
        #1 chk("R5 sub now", int'(sum_comb), 150);
    endtask

    task automatic t_register();
        drive(10, 20, 0, 0);
        en = 1'b1;
        @(posedge clk); #1 chk("R6 load", int'(sum_reg), 30);
        drive(5, 3, 1, 1);
        en = 1'b0;
        @(posedge clk); #1 chk("R7 hold", int'(sum_reg), 30);
        drive(100, 1, 0, 0);
        @(posedge clk); #1 chk("R7 hold2", int'(sum_reg), 30);
        en = 1'b1;
        @(posedge clk); #1 chk("R6 load2", int'(sum_reg), 101);
        @(negedge clk); clr = 1'b1;
        @(posedge clk); #1 chk("R8 clear over en", int'(sum_reg), 0);
        @(negedge clk); clr = 1'b0; en = 1'b0;
        @(posedge clk); #1 chk("R8 stays clear", int'(sum_reg), 0);
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_sub_nocin();
        t_cin_select();
        t_sub_switch();
        t_register();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule